// File: doc/BRIEF.md
# Program Memory Table Access Unit

This unit moves single bytes between the data side of a small processor and its program memory. It holds a 21-bit byte pointer into program memory and an 8-bit holding register. The register file can load either one directly. A table read copies the program memory byte at the pointer into the holding register. A table write sends the holding register and the address to a program memory write port.

Each table instruction word carries a direction bit and a two-bit pointer step mode. The unit decodes the word itself, so the sequencer can present every instruction word and any other word has no effect. An accepted operation occupies exactly two cycles, and `busy` is high for both of them. The program memory port is driven in the first of these cycles. Read data is taken in the second cycle. The pointer step is committed at the end of the second cycle, and a completed read is announced with a one-cycle `lat_valid` pulse.

Top module: `prog_table_access`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `ptr_out` and `lat_out` are zero, and `busy`, `lat_valid`, `pm_rd_en` and `pm_wr_en` are low.
- R2: A word on `op_word` is a table operation only when bits 15..4 are all zero and bit 3 is one. Bit 2 selects write (1) or read (0), and bits 1..0 select the step mode. With `op_valid` high, any other word is ignored: `busy` stays low and no memory access occurs.
- R3: A table operation offered while idle is accepted at that clock edge. `busy` is then high for exactly the next two cycles and low in the cycle after them. Operations offered while `busy` is high are ignored.
- R4: For a read, `pm_rd_en` is high with `pm_addr` equal to the access address in the first busy cycle. `pm_rd_data` is sampled in the second busy cycle. In the cycle after that, `lat_out` shows the sampled byte and `lat_valid` is high for that one cycle only. Bit 0 of `pm_addr` selects the high byte (1) or the low byte (0) of a 16-bit program word.
- R5: For a write, `pm_wr_en` is high in the first busy cycle. In that cycle `pm_addr` equals the access address and `pm_wr_data` equals `lat_out`. `lat_out` is unchanged by the write. `pm_rd_en` and `pm_wr_en` are never high together.
- R6: The step modes are as follows. Mode 00 leaves the pointer unchanged. Mode 01 accesses the old pointer and then adds one. Mode 10 accesses the old pointer and then subtracts one. Mode 11 adds one first and accesses the new value. The new pointer appears on `ptr_out` in the cycle after the last busy cycle.
- R7: Pointer arithmetic wraps modulo 2^21: 0x1FFFFF plus one gives 0, and 0 minus one gives 0x1FFFFF.
- R8: `ptr_ld` and `lat_ld` load their data, visible in the next cycle, only when the unit is idle and no table operation is accepted at that edge. Otherwise they are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Instruction word on op_word is offered |
| op_word | input | 16 | Instruction word to decode |
| ptr_ld | input | 1 | Load pointer from register file |
| ptr_ld_data | input | 21 | Pointer load value |
| lat_ld | input | 1 | Load holding register from register file |
| lat_ld_data | input | 8 | Holding register load value |
| pm_rd_data | input | 8 | Program memory read byte, valid one cycle after pm_rd_en |
| ptr_out | output | 21 | Current pointer, for register file reads |
| lat_out | output | 8 | Current holding register, for register file reads |
| busy | output | 1 | Operation in progress |
| lat_valid | output | 1 | One-cycle pulse after a read completes |
| pm_addr | output | 21 | Program memory byte address |
| pm_rd_en | output | 1 | Program memory read strobe |
| pm_wr_en | output | 1 | Program memory write strobe |
| pm_wr_data | output | 8 | Program memory write byte |

## Verification
Two things can fall in the same cycle: a register-file load and the start of a table operation. The bench provokes this by raising `ptr_ld` or `lat_ld` in the same cycle as an accepted table word. It also raises them while `busy` is high, and during the finishing cycle of a read, when the holding register is being filled from memory. A behavioural model applies the rule that the table operation wins and the load is dropped. The model's pointer, holding register and memory strobes are compared with the design on every cycle, so a load that leaks through shows up either as a wrong write byte or as a wrong final pointer.

// File: rtl/tblacc_pkg.sv
package tblacc_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_ACCESS = 2'd1,
        PH_FINISH = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        STEP_HOLD    = 2'd0,
        STEP_POSTINC = 2'd1,
        STEP_POSTDEC = 2'd2,
        STEP_PREINC  = 2'd3
    } step_e;

endpackage

// File: rtl/tblacc_decode.sv
module tblacc_decode
    import tblacc_pkg::*;
#(
    parameter int OP_W = 16
) (
    input  logic            op_valid,
    input  logic [OP_W-1:0] op_word,
    output logic            hit,
    output logic            is_write,
    output step_e           mode
);
    localparam int HI_W = OP_W - 4;

    logic upper_zero;

    always_comb begin
        upper_zero = (op_word[OP_W-1:4] == {HI_W{1'b0}});
        hit        = op_valid && upper_zero && op_word[3];
        is_write   = op_word[2];
        mode       = step_e'(op_word[1:0]);
    end

endmodule

// File: rtl/tblacc_step.sv
module tblacc_step
    import tblacc_pkg::*;
#(
    parameter int PTR_W = 21
) (
    input  logic [PTR_W-1:0] cur_ptr,
    input  step_e            mode,
    output logic [PTR_W-1:0] acc_addr,
    output logic [PTR_W-1:0] next_ptr
);
    localparam logic [PTR_W-1:0] ONE = {{(PTR_W-1){1'b0}}, 1'b1};

    logic [PTR_W-1:0] plus_one;
    logic [PTR_W-1:0] minus_one;

    always_comb begin
        plus_one  = cur_ptr + ONE;
        minus_one = cur_ptr - ONE;
        acc_addr  = (mode == STEP_PREINC) ? plus_one : cur_ptr;
        unique case (mode)
            STEP_HOLD:    next_ptr = cur_ptr;
            STEP_POSTDEC: next_ptr = minus_one;
            default:      next_ptr = plus_one;
        endcase
    end

endmodule

// File: rtl/prog_table_access.sv
module prog_table_access
    import tblacc_pkg::*;
#(
    parameter int PTR_W  = 21,
    parameter int DATA_W = 8,
    parameter int OP_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [OP_W-1:0]   op_word,
    input  logic              ptr_ld,
    input  logic [PTR_W-1:0]  ptr_ld_data,
    input  logic              lat_ld,
    input  logic [DATA_W-1:0] lat_ld_data,
    input  logic [DATA_W-1:0] pm_rd_data,
    output logic [PTR_W-1:0]  ptr_out,
    output logic [DATA_W-1:0] lat_out,
    output logic              busy,
    output logic              lat_valid,
    output logic [PTR_W-1:0]  pm_addr,
    output logic              pm_rd_en,
    output logic              pm_wr_en,
    output logic [DATA_W-1:0] pm_wr_data
);

    typedef struct packed {
        phase_e            phase;
        logic              wr;
        logic [PTR_W-1:0]  acc;
        logic [PTR_W-1:0]  nptr;
        logic [PTR_W-1:0]  ptr;
        logic [DATA_W-1:0] lat;
        logic              lval;
    } regs_t;

    regs_t r_q, r_d;

    logic             dec_hit;
    logic             dec_wr;
    step_e            dec_mode;
    logic [PTR_W-1:0] step_acc;
    logic [PTR_W-1:0] step_next;

    tblacc_decode #(.OP_W(OP_W)) u_decode (
        .op_valid (op_valid),
        .op_word  (op_word),
        .hit      (dec_hit),
        .is_write (dec_wr),
        .mode     (dec_mode)
    );

    tblacc_step #(.PTR_W(PTR_W)) u_step (
        .cur_ptr  (r_q.ptr),
        .mode     (dec_mode),
        .acc_addr (step_acc),
        .next_ptr (step_next)
    );

    always_comb begin
        r_d      = r_q;
        r_d.lval = 1'b0;
        unique case (r_q.phase)
            PH_IDLE: begin
                if (dec_hit) begin
                    r_d.phase = PH_ACCESS;
                    r_d.wr    = dec_wr;
                    r_d.acc   = step_acc;
                    r_d.nptr  = step_next;
                end else begin
                    if (ptr_ld) r_d.ptr = ptr_ld_data;
                    if (lat_ld) r_d.lat = lat_ld_data;
                end
            end
            PH_ACCESS: r_d.phase = PH_FINISH;
            PH_FINISH: begin
                r_d.phase = PH_IDLE;
                r_d.ptr   = r_q.nptr;
                if (!r_q.wr) begin
                    r_d.lat  = pm_rd_data;
                    r_d.lval = 1'b1;
                end
            end
            default: r_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{phase: PH_IDLE, wr: 1'b0, acc: '0, nptr: '0,
                     ptr: '0, lat: '0, lval: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        ptr_out    = r_q.ptr;
        lat_out    = r_q.lat;
        busy       = (r_q.phase != PH_IDLE);
        lat_valid  = r_q.lval;
        pm_addr    = r_q.acc;
        pm_rd_en   = (r_q.phase == PH_ACCESS) && !r_q.wr;
        pm_wr_en   = (r_q.phase == PH_ACCESS) && r_q.wr;
        pm_wr_data = r_q.lat;
    end

    // R3: the access phase is always followed by the finishing phase
    assert_access_then_finish_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.phase == PH_ACCESS) |=> (r_q.phase == PH_FINISH));

    // R3: the finishing phase always returns to idle
    assert_finish_then_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.phase == PH_FINISH) |=> !busy);

    // R6 / R8: the pointer does not move between acceptance and commit
    assert_ptr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.phase == PH_ACCESS) |=> $stable(ptr_out));

    // R5: never a read and a write strobe together
    assert_single_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pm_rd_en, pm_wr_en}));

    // R4: a completion pulse only follows the finishing phase of a read
    assert_lval_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lat_valid |-> $past(r_q.phase == PH_FINISH && !r_q.wr));

    // R5: a write leaves the holding register untouched
    assert_write_keeps_lat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pm_wr_en |=> $stable(lat_out) && busy);

    // R4: a memory strobe is only ever seen while busy
    assert_strobe_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_rd_en || pm_wr_en) |-> busy);

endmodule

// File: tb/prog_table_access_tb.sv
module prog_table_access_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [15:0] op_word = '0;
    logic        ptr_ld = 1'b0;
    logic [20:0] ptr_ld_data = '0;
    logic        lat_ld = 1'b0;
    logic [7:0]  lat_ld_data = '0;
    logic [7:0]  pm_rd_data = 8'hEE;
    logic [20:0] ptr_out;
    logic [7:0]  lat_out;
    logic        busy;
    logic        lat_valid;
    logic [20:0] pm_addr;
    logic        pm_rd_en;
    logic        pm_wr_en;
    logic [7:0]  pm_wr_data;

    int n_checks = 0;
    int n_fails  = 0;
    bit cmp_on   = 1'b0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prog_table_access dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_word(op_word),
        .ptr_ld(ptr_ld), .ptr_ld_data(ptr_ld_data), .lat_ld(lat_ld),
        .lat_ld_data(lat_ld_data), .pm_rd_data(pm_rd_data), .ptr_out(ptr_out),
        .lat_out(lat_out), .busy(busy), .lat_valid(lat_valid), .pm_addr(pm_addr),
        .pm_rd_en(pm_rd_en), .pm_wr_en(pm_wr_en), .pm_wr_data(pm_wr_data)
    );

    function automatic logic [7:0] memf(input logic [20:0] a);
        return a[7:0] ^ a[15:8] ^ {3'b000, a[20:16]} ^ 8'h5A;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int          m_ph = 0;
    bit          m_wr = 1'b0;
    bit          m_lv = 1'b0;
    logic [20:0] m_ptr = '0, m_acc = '0, m_nptr = '0;
    logic [7:0]  m_lat = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_ptr = '0; m_lat = '0; m_lv = 1'b0; m_wr = 1'b0;
        end else begin
            m_lv = 1'b0;
            if (m_ph == 1) begin
                m_ph = 2;
            end else if (m_ph == 2) begin
                m_ph  = 0;
                m_ptr = m_nptr;
                if (!m_wr) begin
                    m_lat = memf(m_acc);
                    m_lv  = 1'b1;
                end
            end else if (op_valid && op_word[15:4] == 12'h000 && op_word[3]) begin
                m_ph  = 1;
                m_wr  = op_word[2];
                m_acc = (op_word[1:0] == 2'b11) ? m_ptr + 21'd1 : m_ptr;
                case (op_word[1:0])
                    2'b00:   m_nptr = m_ptr;
                    2'b10:   m_nptr = m_ptr - 21'd1;
                    default: m_nptr = m_ptr + 21'd1;
                endcase
            end else begin
                if (ptr_ld) m_ptr = ptr_ld_data;
                if (lat_ld) m_lat = lat_ld_data;
            end
        end
    end

    // memory: data presented in the second busy cycle of a read
    always @(negedge clk) begin
        pm_rd_data <= (m_ph == 2 && !m_wr) ? memf(m_acc) : 8'hEE;
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (cmp_on && !finished) begin
            check("R2 R3 busy", busy, (m_ph != 0));
            check("R4 read strobe", pm_rd_en, (m_ph == 1 && !m_wr));
            check("R5 write strobe", pm_wr_en, (m_ph == 1 && m_wr));
            if (m_ph == 1) check("R4 R5 R6 access address", pm_addr, m_acc);
            if (m_ph == 1 && m_wr) check("R5 write data", pm_wr_data, m_lat);
            check("R6 R7 R8 pointer", ptr_out, m_ptr);
            check("R4 R8 holding register", lat_out, m_lat);
            check("R4 completion pulse", lat_valid, m_lv);
        end
    end

    task automatic step(input bit v, input logic [15:0] w, input bit pl,
                        input logic [20:0] pd, input bit ll, input logic [7:0] ld);
        op_valid = v; op_word = w; ptr_ld = pl; ptr_ld_data = pd;
        lat_ld = ll; lat_ld_data = ld;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 16'h0000, 1'b0, '0, 1'b0, '0);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        logic [31:0] seed;
        seed = 32'h1234_5678;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 ptr", ptr_out, 0);
        check("R1 lat", lat_out, 0);
        check("R1 busy", busy, 0);
        check("R1 lat_valid", lat_valid, 0);
        check("R1 strobes", {pm_rd_en, pm_wr_en}, 0);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        @(negedge clk);
        check("R1 after release", {busy, lat_valid, pm_rd_en, pm_wr_en}, 0);

        // R8: loads while idle
        step(1'b0, 0, 1'b1, 21'h00_1234, 1'b1, 8'hA5);
        idle(1);
        // R4 R6: reads in each mode
        for (int md = 0; md < 4; md++) begin
            step(1'b1, 16'h0008 | 16'(md), 1'b0, '0, 1'b0, '0);
            idle(3);
        end
        // R5 R6: writes in each mode
        for (int md = 0; md < 4; md++) begin
            step(1'b0, 0, 1'b0, '0, 1'b1, 8'(8'h30 + md));
            step(1'b1, 16'h000C | 16'(md), 1'b0, '0, 1'b0, '0);
            idle(3);
        end
        // R7: wrap both ways
        step(1'b0, 0, 1'b1, 21'h1F_FFFF, 1'b0, '0);
        step(1'b1, 16'h0009, 1'b0, '0, 1'b0, '0); idle(3);
        step(1'b0, 0, 1'b1, 21'h1F_FFFF, 1'b0, '0);
        step(1'b1, 16'h000B, 1'b0, '0, 1'b0, '0); idle(3);
        step(1'b1, 16'h000A, 1'b0, '0, 1'b0, '0); idle(3);
        // R2: non-table words ignored
        step(1'b1, 16'h0007, 1'b0, '0, 1'b0, '0);
        step(1'b1, 16'h0018, 1'b0, '0, 1'b0, '0);
        step(1'b1, 16'h8008, 1'b0, '0, 1'b0, '0);
        step(1'b1, 16'h0004, 1'b0, '0, 1'b0, '0);
        step(1'b0, 16'h0008, 1'b0, '0, 1'b0, '0);
        idle(2);
        // R3 R8: collisions - load with op start, op and loads while busy
        step(1'b1, 16'h000D, 1'b1, 21'h0A_AAAA, 1'b1, 8'h77);
        step(1'b1, 16'h0009, 1'b1, 21'h05_5555, 1'b1, 8'h66);
        step(1'b1, 16'h000A, 1'b1, 21'h03_3333, 1'b1, 8'h55);
        idle(2);
        step(1'b1, 16'h0008, 1'b0, '0, 1'b0, '0);
        step(1'b0, 0, 1'b0, '0, 1'b0, '0);
        step(1'b0, 0, 1'b0, '0, 1'b1, 8'h11);
        idle(2);
        // R3: operation held continuously, back to back
        for (int i = 0; i < 9; i++) step(1'b1, 16'h0009, 1'b0, '0, 1'b0, '0);
        idle(3);
        // mixed pseudo-random traffic
        for (int i = 0; i < 600; i++) begin
            logic [15:0] w;
            seed = seed * 32'd1664525 + 32'd1013904223;
            w = seed[27] ? (16'h0008 | {13'h0, seed[10:8]}) : seed[31:16];
            step(seed[26] | seed[25], w, seed[24] & seed[23], {seed[20:0]},
                 seed[22], seed[15:8]);
        end
        idle(4);
        finish_run();
    end

endmodule